// File: doc/BRIEF.md
# Up/Down and Center-Aligned Timer Counter Core

This block is a 16-bit timer counter run by an 8-bit control register. It counts one step on each cycle where the tick enable is high and the counter is enabled. In edge mode it counts in a single direction chosen by software. In the three center modes it runs up to the reload limit and back down to zero, over and over. The center modes differ only in which direction lets the compare flags of a neighbouring compare unit set. The block drives a qualifier output for that unit.

The reload limit can take effect at once, or it can be staged in a shadow register that is copied over only on an update event. An update event comes from a counter wrap or turnaround, from a software strobe or from an external trigger strobe. Software decides whether all three sources, or only the counter, may raise the sticky update flag. Updates can be inhibited as a whole. A one-shot mode makes the counter disable itself at its next update event.

Top module: `tmr_core`

## Requirements
- R1: After reset the control readback is 0x00, the counter is 0, the update flag is 0 and the direction output is 0. The reload limit resets to all ones.
- R2: The control byte fields are: bit 7 staging enable, bits 6:5 count mode, bit 4 direction (0 up, 1 down), bit 3 one-shot, bit 2 counter-only flag source, bit 1 update inhibit, bit 0 counter enable. `ctrl_o` reads back the fields written, with bit 4 showing the current direction.
- R3: In edge mode (bits 6:5 = 00) with direction 0, each enabled tick adds one. When the counter is at or above the reload limit, the next tick sets it to 0 and makes a counter event.
- R4: In edge mode with direction 1, each enabled tick subtracts one. At 0 the next tick loads the reload limit and makes a counter event.
- R5: In center modes (01, 10, 11) the counter counts up until it reaches the limit and then turns down. It counts down until it reaches 0 and then turns up. Each turnaround is a counter event and flips `dir_o` in the same cycle.
- R6: `cmp_ok_o` depends on the mode: it is 1 in mode 00, equals `dir_o` in mode 01 (down only), equals the inverse of `dir_o` in mode 10 (up only), and is 1 in mode 11.
- R7: In a center mode, written direction bits are ignored. `dir_o` and readback bit 4 show the hardware direction.
- R8: A control write that would move bits 6:5 from 00 to a nonzero value while bit 0 is 1 leaves bits 6:5 at 00. The other fields of that write still take effect.
- R9: With staging off, a limit write takes effect at the next edge. With staging on, it goes to the shadow, and the shadow is copied to the active limit at each update event.
- R10: With one-shot set, an update event clears bit 0 and counting stops.
- R11: With bit 2 = 0, any update event sets the flag. With bit 2 = 1, only counter events set it.
- R12: With bit 1 = 1 there are no update events: the flag is not set, the shadow is not copied, and the software strobe does not reinitialise the counter.
- R13: The software strobe, when updates are allowed, sets the counter to 0 if the direction is up and to the limit if it is down. The flag stays set until the `flag_clr_i` pulse clears it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| lim_we_i | input | 1 | Reload limit write strobe |
| lim_wdata_i | input | 16 | Reload limit write data |
| tick_i | input | 1 | Count enable tick |
| sw_upd_i | input | 1 | Software update strobe |
| trg_upd_i | input | 1 | External trigger update strobe |
| flag_clr_i | input | 1 | Update flag clear (write-zero) strobe |
| cnt_o | output | 16 | Counter value |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_ok_o | output | 1 | Compare flags may set in current direction |
| dir_o | output | 1 | Current direction, 1 = down |
| ctrl_o | output | 8 | Control byte readback |

## Verification
Counting is tried with steady ticks and with gapped ticks. It is run in edge mode up and down, and in each of the center modes. Wrap values tell edge up apart from edge down. Turnaround points and the qualifier tell the three center modes apart. A limit write during counting separates staged from immediate reload: the counter passes the new limit only if staging holds it back. Strobes under each flag-source and inhibit setting separate counter events from software and trigger events. A final phase runs pseudo-random writes and strobes against the reference model, so that combinations of inputs in the same cycle are also covered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    CM_EDGE = 2'b00,
    CM_DOWN = 2'b01,
    CM_UP   = 2'b10,
    CM_BOTH = 2'b11
  } cmode_e;

  typedef struct packed {
    logic   stage;
    cmode_e mode;
    logic   dir;
    logic   oneshot;
    logic   cnt_only;
    logic   inhibit;
    logic   en;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              stop_i,
  output ctrl_t             ctrl_o
);
  ctrl_t q, nxt;

  always_comb begin
    nxt = ctrl_t'(wdata_i);
    // no edge-to-center switch while running
    if (q.mode == CM_EDGE && q.en && nxt.mode != CM_EDGE) nxt.mode = q.mode;
    // direction owned by hardware in center modes
    if (nxt.mode != CM_EDGE) nxt.dir = q.dir;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (we_i) q <= nxt;
      if (stop_i) q.en <= 1'b0;
    end
  end

  assign ctrl_o = q;
endmodule

// File: rtl/tmr_limit.sv
module tmr_limit #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stage_i,
  input  logic         uev_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] ld_o
);
  logic [W-1:0] act_q, shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST_VAL;
      shd_q <= RST_VAL;
    end else begin
      if (uev_i) act_q <= shd_q;
      if (we_i && !stage_i) act_q <= wdata_i;
      if (we_i) shd_q <= wdata_i;
    end
  end

  assign act_o = act_q;
  // value that becomes active at this edge
  assign ld_o  = uev_i ? shd_q : act_q;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         center_i,
  input  logic         dir_sw_i,
  input  logic [W-1:0] lim_i,
  input  logic [W-1:0] lim_ld_i,
  input  logic         reinit_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         evt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_nxt;
  logic [W:0]   inc_w;
  logic         dir_hw_q, step, wrap;

  assign inc_w = {1'b0, cnt_q} + {1'b0, ONE};
  assign dir_o = center_i ? dir_hw_q : dir_sw_i;
  assign step  = en_i && tick_i && !reinit_i;

  always_comb begin
    if (!center_i) wrap = dir_sw_i ? (cnt_q == '0) : (cnt_q >= lim_i);
    else           wrap = dir_hw_q ? (cnt_q <= ONE) : (inc_w >= {1'b0, lim_i});
  end

  assign evt_o = step && wrap;

  always_comb begin
    if (!center_i) begin
      if (dir_sw_i) cnt_nxt = wrap ? lim_ld_i : cnt_q - ONE;
      else          cnt_nxt = wrap ? '0 : inc_w[W-1:0];
    end else begin
      if (dir_hw_q) cnt_nxt = wrap ? '0 : cnt_q - ONE;
      else          cnt_nxt = wrap ? lim_i : inc_w[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_hw_q <= 1'b0;
    end else begin
      if (reinit_i)  cnt_q <= dir_o ? lim_ld_i : '0;
      else if (step) cnt_q <= cnt_nxt;
      if (!center_i)  dir_hw_q <= dir_sw_i;
      else if (evt_o) dir_hw_q <= ~dir_hw_q;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] LIM_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              lim_we_i,
  input  logic [CNT_W-1:0]  lim_wdata_i,
  input  logic              tick_i,
  input  logic              sw_upd_i,
  input  logic              trg_upd_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_flag_o,
  output logic              cmp_ok_o,
  output logic              dir_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] lim_act, lim_ld;
  logic             evt, uev, reinit, center;

  assign center = (ctrl.mode != CM_EDGE);
  assign reinit = sw_upd_i && !ctrl.inhibit;
  assign uev    = !ctrl.inhibit && (evt || sw_upd_i || trg_upd_i);

  tmr_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .stop_i  (uev && ctrl.oneshot),
    .ctrl_o  (ctrl)
  );

  tmr_limit #(.W(CNT_W), .RST_VAL(LIM_RST)) u_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lim_we_i),
    .wdata_i (lim_wdata_i),
    .stage_i (ctrl.stage),
    .uev_i   (uev),
    .act_o   (lim_act),
    .ld_o    (lim_ld)
  );

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl.en),
    .tick_i   (tick_i),
    .center_i (center),
    .dir_sw_i (ctrl.dir),
    .lim_i    (lim_act),
    .lim_ld_i (lim_ld),
    .reinit_i (reinit),
    .cnt_o    (cnt_o),
    .dir_o    (dir_o),
    .evt_o    (evt)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (uev && (!ctrl.cnt_only || evt)),
    .clr_i  (flag_clr_i),
    .flag_o (upd_flag_o)
  );

  always_comb begin
    unique case (ctrl.mode)
      CM_DOWN: cmp_ok_o = dir_o;
      CM_UP:   cmp_ok_o = !dir_o;
      default: cmp_ok_o = 1'b1;
    endcase
  end

  assign ctrl_o = {ctrl.stage, ctrl.mode, dir_o, ctrl.oneshot,
                   ctrl.cnt_only, ctrl.inhibit, ctrl.en};
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [7:0]  ctrl_wdata_i,
  input logic        lim_we_i,
  input logic [15:0] lim_wdata_i,
  input logic        tick_i,
  input logic        sw_upd_i,
  input logic        trg_upd_i,
  input logic        flag_clr_i,
  input logic [15:0] cnt_o,
  input logic        upd_flag_o,
  input logic        cmp_ok_o,
  input logic        dir_o,
  input logic [7:0]  ctrl_o
);
  assert_flag_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_flag_o && !flag_clr_i) |=> upd_flag_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0] && !sw_upd_i) |=> $stable(cnt_o));

  assert_inhibit_noflag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[1] && !upd_flag_o) |=> !upd_flag_o);

  assert_mode_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_o[0] && ctrl_o[6:5] == 2'b00) |=> ctrl_o[6:5] == 2'b00);

  assert_src_filter_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] && !ctrl_o[0] && !upd_flag_o) |=> !upd_flag_o);

  assert_qual_up_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[6:5] == 2'b10) |-> (cmp_ok_o != dir_o));

  assert_dir_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[6:5] != 2'b00 && !tick_i && !ctrl_we_i) |=> $stable(dir_o));
endmodule

bind tmr_core tmr_core_chk u_chk (.*);

// File: tb/tmr_core_test.sv
module tmr_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we = 0, lim_we = 0, tick = 0, sw_upd = 0, trg_upd = 0, flag_clr = 0;
  logic [7:0]  ctrl_wdata = 0;
  logic [15:0] lim_wdata = 0;
  logic [15:0] cnt;
  logic        flag, cmp_ok, dir;
  logic [7:0]  ctrl;

  int n_chk = 0, n_fail = 0;
  bit run = 0, done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tmr_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .lim_we_i(lim_we), .lim_wdata_i(lim_wdata), .tick_i(tick), .sw_upd_i(sw_upd),
    .trg_upd_i(trg_upd), .flag_clr_i(flag_clr), .cnt_o(cnt), .upd_flag_o(flag),
    .cmp_ok_o(cmp_ok), .dir_o(dir), .ctrl_o(ctrl)
  );

  // reference model state
  int m_cnt, m_act, m_pre, m_mode;
  bit m_stage, m_dir, m_one, m_conly, m_inh, m_en, m_dhw, m_flag;

  function automatic bit m_dir_eff();
    return (m_mode != 0) ? m_dhw : m_dir;
  endfunction

  function automatic int m_ctrl();
    return (int'(m_stage) << 7) | (m_mode << 5) | (int'(m_dir_eff()) << 4) |
           (int'(m_one) << 3) | (int'(m_conly) << 2) | (int'(m_inh) << 1) | int'(m_en);
  endfunction

  function automatic bit m_cmp();
    case (m_mode)
      1: return m_dir_eff();
      2: return !m_dir_eff();
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_act = 65535; m_pre = 65535; m_mode = 0;
      {m_stage, m_dir, m_one, m_conly, m_inh, m_en, m_dhw, m_flag} = '0;
    end else begin
      bit center, d, reinit, evt, uev, ndhw;
      int ld, ncnt, nmode, nact, npre;
      center = (m_mode != 0);
      d = m_dir_eff();
      reinit = sw_upd && !m_inh;
      evt = 0; ncnt = m_cnt; ndhw = m_dhw;
      if (m_en && tick && !reinit) begin
        if (!center && !d) evt = (m_cnt >= m_act);
        else if (!center)  evt = (m_cnt == 0);
        else if (!d)       evt = (m_cnt + 1 >= m_act);
        else               evt = (m_cnt <= 1);
      end
      uev = !m_inh && (evt || sw_upd || trg_upd);
      ld = uev ? m_pre : m_act;
      if (reinit) ncnt = d ? ld : 0;
      else if (m_en && tick) begin
        if (!center && !d)     ncnt = evt ? 0 : m_cnt + 1;
        else if (!center)      ncnt = evt ? ld : m_cnt - 1;
        else if (!d)           ncnt = evt ? m_act : m_cnt + 1;
        else                   ncnt = evt ? 0 : m_cnt - 1;
      end
      if (!center) ndhw = m_dir; else if (evt) ndhw = !m_dhw;
      nact = m_act; npre = m_pre;
      if (uev) nact = m_pre;
      if (lim_we && !m_stage) nact = lim_wdata;
      if (lim_we) npre = lim_wdata;
      if (uev && (!m_conly || evt)) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (uev && m_one) begin end
      begin
        bit one_old;
        one_old = m_one;
        if (ctrl_we) begin
          nmode = ctrl_wdata[6:5];
          if (m_mode == 0 && m_en && nmode != 0) nmode = 0;
          if (nmode == 0) m_dir = ctrl_wdata[4];
          m_mode = nmode;
          m_stage = ctrl_wdata[7]; m_one = ctrl_wdata[3]; m_conly = ctrl_wdata[2];
          m_inh = ctrl_wdata[1]; m_en = ctrl_wdata[0];
        end
        if (uev && one_old) m_en = 0;
      end
      m_cnt = ncnt & 16'hFFFF; m_dhw = ndhw; m_act = nact; m_pre = npre;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && run) begin
      chk(cnt == 16'(m_cnt), cur_req, "cnt", cnt, m_cnt);
      chk(flag == m_flag, cur_req, "flag", flag, m_flag);
      chk(dir == m_dir_eff(), cur_req, "dir", dir, m_dir_eff());
      chk(cmp_ok == m_cmp(), cur_req, "cmp_ok", cmp_ok, m_cmp());
      chk(ctrl == 8'(m_ctrl()), cur_req, "ctrl", ctrl, m_ctrl());
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_lim(input logic [15:0] v);
    lim_we = 1; lim_wdata = v; @(negedge clk); lim_we = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; @(negedge clk); end
    tick = 0;
  endtask
  task automatic pulse_sw();  sw_upd = 1;  @(negedge clk); sw_upd = 0;  endtask
  task automatic pulse_trg(); trg_upd = 1; @(negedge clk); trg_upd = 0; endtask
  task automatic pulse_clr(); flag_clr = 1; @(negedge clk); flag_clr = 0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(ctrl == 8'h00, "R1", "reset ctrl", ctrl, 0);
    chk(cnt == 0 && flag == 0 && dir == 0, "R1", "reset cnt/flag/dir", {cnt, flag, dir}, 0);
    run = 1;

    cur_req = "R3";
    wr_lim(16'd4);
    wr_ctrl(8'h01);
    ticks(5);
    chk(cnt == 0 && flag, "R3", "edge up wrap", cnt, 0);
    tick = 1; @(negedge clk); tick = 0; @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk(cnt == 2, "R3", "gapped ticks", cnt, 2);
    pulse_sw();

    cur_req = "R4";
    pulse_clr();
    wr_ctrl(8'h11);
    ticks(1);
    chk(cnt == 4 && flag, "R4", "edge down wrap", cnt, 4);
    ticks(3);
    chk(cnt == 1, "R4", "edge down step", cnt, 1);

    cur_req = "R8";
    wr_ctrl(8'h61);
    chk(ctrl == 8'h01, "R8", "mode switch blocked", ctrl, 8'h01);

    cur_req = "R13";
    wr_ctrl(8'h00);
    pulse_sw();
    chk(cnt == 0 && flag, "R13", "sw reinit up", cnt, 0);

    cur_req = "R5";
    wr_ctrl(8'h60);
    wr_ctrl(8'h61);
    ticks(4);
    chk(cnt == 4 && dir == 1, "R5", "top turnaround", {cnt, dir}, {16'd4, 1'b1});
    ticks(4);
    chk(cnt == 0 && dir == 0, "R5", "bottom turnaround", {cnt, dir}, 0);

    cur_req = "R7";
    wr_ctrl(8'h71);
    chk(dir == 0 && ctrl[4] == 0, "R7", "dir write ignored", dir, 0);
    ticks(1);
    chk(cnt == 1, "R7", "still counting up", cnt, 1);

    cur_req = "R6";
    wr_ctrl(8'h21);
    chk(cmp_ok == 0, "R6", "down-only while up", cmp_ok, 0);
    ticks(3);
    chk(cnt == 4 && cmp_ok == 1, "R6", "down-only while down", cmp_ok, 1);
    wr_ctrl(8'h41);
    chk(cmp_ok == 0, "R6", "up-only while down", cmp_ok, 0);
    wr_ctrl(8'h61);
    chk(cmp_ok == 1, "R6", "both", cmp_ok, 1);

    cur_req = "R9";
    wr_ctrl(8'h00);
    wr_ctrl(8'h80);
    pulse_sw();
    wr_lim(16'd2);
    wr_ctrl(8'h81);
    ticks(3);
    chk(cnt == 3, "R9", "staged limit not yet active", cnt, 3);
    ticks(2);
    ticks(3);
    chk(cnt == 0, "R9", "staged limit active after update", cnt, 0);

    cur_req = "R10";
    wr_ctrl(8'h09);
    ticks(3);
    chk(ctrl[0] == 0 && cnt == 0, "R10", "oneshot stop", ctrl, 8'h08);
    ticks(2);
    chk(cnt == 0, "R10", "stopped", cnt, 0);

    cur_req = "R11";
    pulse_clr();
    wr_ctrl(8'h04);
    pulse_sw();
    pulse_trg();
    chk(flag == 0, "R11", "counter-only source", flag, 0);
    wr_ctrl(8'h00);
    pulse_trg();
    chk(flag == 1, "R11", "trigger source", flag, 1);

    cur_req = "R12";
    pulse_clr();
    wr_ctrl(8'h03);
    ticks(2);
    pulse_sw();
    chk(cnt == 2 && flag == 0, "R12", "inhibit blocks sw", cnt, 2);
    ticks(1);
    chk(cnt == 0 && flag == 0, "R12", "inhibit wrap no flag", flag, 0);

    cur_req = "R13";
    wr_ctrl(8'h01);
    ticks(3);
    ticks(1);
    chk(flag == 1, "R13", "flag sticky", flag, 1);
    pulse_clr();
    chk(flag == 0, "R13", "flag cleared", flag, 0);

    cur_req = "R2";
    wr_ctrl(8'h00);
    wr_ctrl(8'hAE);
    chk(ctrl == 8'hAE, "R2", "field readback", ctrl, 8'hAE);

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tick = lf[0] | lf[1];
      sw_upd = (lf[7:3] == 5'd3);
      trg_upd = (lf[7:3] == 5'd9);
      flag_clr = (lf[6:4] == 3'd5);
      lim_we = (lf[11:8] == 4'd2);
      lim_wdata = 16'(lf[14:12]);
      ctrl_we = (lf[15:11] == 5'd7);
      ctrl_wdata = {lf[2], lf[9:8], lf[5], lf[10], 1'b0, lf[3] & lf[4], 1'b1};
      @(negedge clk);
    end
    {tick, sw_upd, trg_upd, flag_clr, lim_we, ctrl_we} = '0;
    @(negedge clk);
    finish_run();
  end
endmodule